// File: doc/BRIEF.md
# Successive-Approximation Conversion Timing Engine

This block runs a single successive-approximation conversion. A start pulse captures three settings: the resolution, the sample-time code and the prescaler value. The engine then derives a slower conversion clock from the bus clock and spends a sampling interval in two phases. The first phase is a fixed two conversion clocks. The second phase has a programmable length. After sampling, the engine resolves the result most significant bit first. It spends one conversion clock per bit, driving a trial code to an external DAC and reading back a single comparator decision.

The finished code is offered on a valid/ready result port. The result stays on the port, unchanged, until the consumer takes it. The engine accepts no new start until that handshake completes, so a slow consumer stalls the engine rather than losing data. Start, abort, and the settings inputs are plain control pins. An abort drops any conversion or pending result at once.

Top module: `sar_conv_engine`

## Requirements
- R1: A start pulse seen while idle captures the settings and begins a conversion. The result becomes valid exactly (2 + S + B) conversion clocks later. S is 2, 4, 8 or 16 for `smp_sel_i` = 0, 1, 2, 3. B is 10, or 8 in narrow mode.
- R2: One conversion clock lasts 2×(`prs_i`+1) bus clocks, for `prs_i` from 0 to 31.
- R3: With `narrow_i`=0, bits 9 down to 0 are decided in order. A bit is kept when `cmp_ge_i` is high (input at or above the trial code). Otherwise it is cleared. The result is therefore the largest 10-bit code not above the input.
- R4: With `narrow_i`=1, only bits 9 down to 2 are decided, and result bits 1:0 are zero.
- R5: While `res_valid_o` is high and `res_ready_i` is low, `res_valid_o` stays high and `res_data_o` stays unchanged. The engine returns to idle at the handshake clock edge.
- R6: When `abort_i` is high at a clock edge, the engine is idle after that edge. From then on `res_valid_o` and `dac_code_o` are zero, and the aborted conversion never produces a result.
- R7: A start pulse during sampling, during conversion or while a result waits is ignored.
- R8: `dac_code_o` is zero outside the bit-decision phase. The first trial code of each conversion is midscale, 512 (only bit 9 set).
- R9: Changing `narrow_i`, `smp_sel_i` or `prs_i` after the start has no effect on a running conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a conversion (sampled while idle) |
| abort_i | input | 1 | Cancel any activity and return to idle |
| narrow_i | input | 1 | 1 selects 8-bit resolution, 0 selects 10-bit |
| smp_sel_i | input | 2 | Second sample phase length code |
| prs_i | input | 5 | Conversion clock prescaler |
| dac_code_o | output | 10 | Trial code to the DAC |
| cmp_ge_i | input | 1 | Comparator: input at or above trial code |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Consumer accepts the result |
| res_data_o | output | 10 | Conversion result, MSB-aligned |

## Verification
The assertions assume `cmp_ge_i` settles combinationally from `dac_code_o` within the same bus clock. They also assume that the consumer may hold `res_ready_i` low for any length of time. The bench meets the first assumption with a comparator model that is a direct compare of a held input value against the DAC code. It changes that input value only while the engine is idle. The second assumption is tested by holding ready low for several cycles after a result appears. Aborts and the redundant start and settings changes are driven mid-conversion, not at phase boundaries.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAMP = 2'd1,
    ST_CONV = 2'd2,
    ST_HOLD = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_clkdiv.sv
// Conversion clock enable: one tick every 2*(prs+1) bus clocks while running.
module sar_clkdiv #(
  parameter int PRS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRS_W-1:0] prs,
  output logic             tick
);
  localparam int DW = PRS_W + 1;

  logic [DW-1:0] div_q;
  logic [DW-1:0] top;

  assign top  = {prs, 1'b1};
  assign tick = run && (div_q == top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     div_q <= '0;
    else if (!run)  div_q <= '0;
    else if (tick)  div_q <= '0;
    else            div_q <= div_q + 1'b1;
  end

  // R2: the shortest conversion clock is two bus clocks
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/sar_samp_timer.sv
// Counts the two-phase sample window in conversion clocks.
module sar_samp_timer #(
  parameter int SMP_W    = 2,
  parameter int FIRST_PH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [SMP_W-1:0] smp_sel,
  output logic             done
);
  localparam int MAX_LEN = FIRST_PH + (2 << ((1 << SMP_W) - 1));
  localparam int CW      = $clog2(MAX_LEN + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len;

  assign len  = CW'(FIRST_PH) + (CW'(2) << smp_sel);
  assign done = run && tick && (cnt_q == len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!run)  cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + 1'b1;
  end

  // R1: the count never runs past the programmed sample length
  p_samp_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < len));
endmodule

// File: rtl/sar_approx.sv
// Successive-approximation register: trial mask walks MSB to LSB.
module sar_approx #(
  parameter int W   = 10,
  parameter int LOW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         cmp_ge,
  input  logic         narrow,
  output logic [W-1:0] trial,
  output logic [W-1:0] acc,
  output logic         last
);
  localparam logic [W-1:0] MSB_M    = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] END_WIDE = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] END_NAR  = {{(LOW-1){1'b0}}, 1'b1, {(W-LOW){1'b0}}};

  logic [W-1:0] acc_q;
  logic [W-1:0] mask_q;

  assign trial = acc_q | mask_q;
  assign acc   = acc_q;
  assign last  = (mask_q == (narrow ? END_NAR : END_WIDE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      mask_q <= '0;
    end else if (load) begin
      acc_q  <= '0;
      mask_q <= MSB_M;
    end else if (step) begin
      if (cmp_ge) acc_q <= acc_q | mask_q;
      mask_q <= mask_q >> 1;
    end
  end

  // R8: only one undecided bit is ever on trial
  p_mask_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_q));
  // R8: every conversion opens with the midscale trial
  p_first_trial_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (trial == MSB_M));
  // R3: a decided bit is never cleared by a later step
  p_acc_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ((acc_q & $past(acc_q)) == $past(acc_q)));
endmodule

// File: rtl/sar_conv_engine.sv
module sar_conv_engine
  import sar_pkg::*;
#(
  parameter int RES_W    = 10,
  parameter int RES_N    = 8,
  parameter int PRS_W    = 5,
  parameter int SMP_W    = 2,
  parameter int FIRST_PH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             narrow_i,
  input  logic [SMP_W-1:0] smp_sel_i,
  input  logic [PRS_W-1:0] prs_i,
  output logic [RES_W-1:0] dac_code_o,
  input  logic             cmp_ge_i,
  output logic             res_valid_o,
  input  logic             res_ready_i,
  output logic [RES_W-1:0] res_data_o
);
  localparam int PAD = RES_W - RES_N;

  sar_state_e       state_q, state_d;
  logic             narrow_q;
  logic [SMP_W-1:0] smp_q;
  logic [PRS_W-1:0] prs_q;
  logic             tick, samp_done, step, last;
  logic [RES_W-1:0] trial, acc;

  assign step = tick && (state_q == ST_CONV);

  sar_clkdiv #(.PRS_W(PRS_W)) u_div (
    .clk(clk), .rst_n(rst_n),
    .run((state_q == ST_SAMP) || (state_q == ST_CONV)),
    .prs(prs_q), .tick(tick));

  sar_samp_timer #(.SMP_W(SMP_W), .FIRST_PH(FIRST_PH)) u_samp (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_SAMP),
    .tick(tick), .smp_sel(smp_q), .done(samp_done));

  sar_approx #(.W(RES_W), .LOW(RES_N)) u_sar (
    .clk(clk), .rst_n(rst_n), .load(samp_done), .step(step),
    .cmp_ge(cmp_ge_i), .narrow(narrow_q), .trial(trial), .acc(acc),
    .last(last));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_SAMP;
      ST_SAMP: if (samp_done) state_d = ST_CONV;
      ST_CONV: if (step && last) state_d = ST_HOLD;
      ST_HOLD: if (res_ready_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (abort_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      narrow_q <= 1'b0;
      smp_q    <= '0;
      prs_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        narrow_q <= narrow_i;
        smp_q    <= smp_sel_i;
        prs_q    <= prs_i;
      end
    end
  end

  assign dac_code_o  = (state_q == ST_CONV) ? trial : '0;
  assign res_valid_o = (state_q == ST_HOLD);
  assign res_data_o  = (state_q == ST_HOLD) ? acc : '0;

  // R6: abort empties the engine by the next edge
  p_abort_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!res_valid_o && dac_code_o == '0));
  // R5: a stalled result stays put
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i && !abort_i) |=> (res_valid_o && $stable(res_data_o)));
  // R4: narrow results carry zero padding below the decided bits
  p_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && narrow_q) |-> (res_data_o[PAD-1:0] == '0));
  // R9: captured settings do not move while a conversion runs
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ((state_q == ST_IDLE) || $stable({narrow_q, smp_q, prs_q})));
endmodule

// File: tb/sar_conv_engine_test.sv
`timescale 1ns/1ps
module sar_conv_engine_test;
  logic       clk = 1'b0;
  logic       rst_n, start, abort, narrow, ready, cmp_ge, res_valid;
  logic [1:0] smp_sel;
  logic [4:0] prs;
  logic [9:0] dac_code, res_data, vin;

  always #4 clk = ~clk;

  assign cmp_ge = (vin >= dac_code);

  sar_conv_engine uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort),
    .narrow_i(narrow), .smp_sel_i(smp_sel), .prs_i(prs),
    .dac_code_o(dac_code), .cmp_ge_i(cmp_ge), .res_valid_o(res_valid),
    .res_ready_i(ready), .res_data_o(res_data));

  int    cyc = 0;
  int    errs = 0, checks = 0;
  int    t0 = 0, pushed = 0, popped = 0;
  bit    seen = 0, dac_seen = 1, done_all = 0;
  int    exp_data_q[$];
  int    exp_lat_q[$];
  string tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_res(input int v, input bit n);
    return n ? (v & 'h3FC) : v;
  endfunction

  function automatic int exp_lat(input bit n, input int s, input int p);
    return (2 + (2 << s) + (n ? 8 : 10)) * 2 * (p + 1);
  endfunction

  // Monitor: latency at first sight of valid, data at handshake
  always @(negedge clk) begin
    if (rst_n) begin
      if (dac_code != 0 && !dac_seen) begin
        dac_seen = 1;
        chk(dac_code == 512, "R8 first trial", dac_code, 512);
      end
      if (res_valid && !seen) begin
        seen = 1;
        if (exp_lat_q.size() > 0)
          chk(cyc - t0 == exp_lat_q[0], "R1/R2 latency", cyc - t0, exp_lat_q[0]);
      end
      if (res_valid && ready) begin
        if (exp_data_q.size() > 0) begin
          chk(res_data == exp_data_q[0], tag_q[0], res_data, exp_data_q[0]);
          void'(exp_data_q.pop_front());
          void'(exp_lat_q.pop_front());
          void'(tag_q.pop_front());
        end else begin
          chk(1'b0, "R6/R7 unexpected result", res_data, -1);
        end
        popped++;
        seen = 0;
      end
    end
  end

  // Driver: one conversion, optionally disturbed (R7/R9) or stalled (R5)
  task automatic conv(input int v, input bit n, input int s, input int p,
                      input bit disturb, input bit stall);
    @(negedge clk);
    vin = 10'(v); narrow = n; smp_sel = 2'(s); prs = 5'(p);
    ready = !stall;
    exp_data_q.push_back(exp_res(v, n));
    exp_lat_q.push_back(exp_lat(n, s, p));
    tag_q.push_back(n ? "R4 narrow data" : "R3 wide data");
    pushed++;
    dac_seen = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    t0 = cyc;
    if (disturb) begin
      repeat (10) @(negedge clk);
      narrow = !n; smp_sel = 2'(3 - s); prs = 5'(31 - p);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    if (stall) begin
      while (!res_valid) @(negedge clk);
      repeat (5) @(negedge clk);
      chk(res_valid && res_data == 10'(exp_res(v, n)), "R5 stalled hold",
          res_data, exp_res(v, n));
      ready = 1;
    end
    while (popped != pushed) @(negedge clk);
    @(negedge clk);
    chk(dac_code == 0 && !res_valid, "R8 idle dac", dac_code, 0);
  endtask

  initial begin
    rst_n = 0; start = 0; abort = 0; narrow = 0; smp_sel = 0; prs = 0;
    ready = 1; vin = 0;
    repeat (3) @(negedge clk);
    chk(!res_valid && dac_code == 0, "R6/R8 reset state", res_valid, 0);
    rst_n = 1;
    @(negedge clk);

    conv(0,    0, 0, 0, 0, 0);
    conv(1023, 0, 3, 0, 0, 0);
    conv(512,  0, 1, 1, 0, 0);
    conv(511,  0, 2, 0, 0, 0);
    conv(300,  0, 0, 3, 0, 0);
    conv(1023, 1, 0, 0, 0, 0);
    conv(3,    1, 3, 1, 0, 0);
    conv(513,  1, 1, 0, 0, 0);
    conv(777,  1, 2, 31, 0, 0);
    conv(700,  0, 1, 2, 1, 0);   // R7/R9 disturbed
    conv(401,  1, 2, 0, 1, 0);   // R7/R9 disturbed, narrow
    conv(95,   0, 0, 1, 0, 1);   // R5 stall

    // R6 abort during conversion
    @(negedge clk);
    vin = 10'd600; narrow = 0; smp_sel = 0; prs = 0; dac_seen = 1;
    start = 1; @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    abort = 1; @(negedge clk); abort = 0;
    chk(!res_valid && dac_code == 0, "R6 abort idle", dac_code, 0);
    begin
      int hits = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (res_valid || dac_code != 0) hits++;
      end
      chk(hits == 0, "R6 no result after abort", hits, 0);
    end
    // R6 abort while a result waits
    conv(250, 0, 0, 0, 0, 0);
    @(negedge clk);
    ready = 0; vin = 10'd42; start = 1; @(negedge clk); start = 0;
    while (!res_valid) @(negedge clk);
    abort = 1; @(negedge clk); abort = 0; ready = 1;
    chk(!res_valid, "R6 abort drops pending result", res_valid, 0);
    conv(842, 0, 1, 0, 0, 0);

    done_all = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_all) begin
      errs++; checks++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule